// File: doc/BRIEF.md
# External Bus Mastership Arbiter

This block decides when a bus-owning controller hands its external memory bus to an outside requester, and when it takes the bus back. The controller owns the bus after reset. An outside master asks for the bus by pulling an active-low request line. The arbiter waits for the current bus cycle to finish and for every indivisible access sequence to clear. If an SDRAM bank is still open, it first asks for a precharge-all command. It then floats the bus in stages and answers with an active-low acknowledge. When the outside master lets go of the request, the arbiter drives the control lines high again, withdraws the acknowledge and then lets normal bus cycles resume.

The arbiter runs on one clock at twice the bus clock rate. An internal phase bit, shown on `bus_ph`, tells the two half-periods apart. `bus_ph` = 0 is the half after a bus-clock rising edge. `bus_ph` = 1 is the half after a falling edge. The request line is sampled only at the fast-clock edge that starts a `bus_ph` = 1 half. Every output is registered, so each output changes on a defined rising or falling bus-clock slot.

While the bus is granted away, a pending SDRAM refresh is signalled to the outside master on `refresh_req`. This asks the outside master to return the bus.

Top module: `bus_arbiter`

## Requirements
- R1: After reset `bus_owned`=1, `back_n`=1, `addr_data_oe`=1, `ctrl_oe`=1, `ctrl_drive_high`=0, `pall_req`=0, `refresh_req`=0.
- R2: `breq_n` is sampled only at the fast-clock edge that ends a `bus_ph`=0 cycle. A low level present only during a `bus_ph`=1 cycle has no effect.
- R3: A release is decided in a `bus_ph`=1 cycle. Measured in edges from the sampling edge, `addr_data_oe` and `bus_owned` go low 1 edge later, in a `bus_ph`=0 cycle. `back_n` goes low 2 edges later, in a `bus_ph`=1 cycle. `ctrl_oe` goes low 3 edges later.
- R4: While any bit of `atomic_busy` is 1, no release is started.
- R5: While `lock` is 1, no release is started.
- R6: While `dma_burst` is 1, the request is held off when `dma_prio`=2'b00 and honoured for any other value.
- R7: While `cyc_done` is 0, no release is started.
- R8: If `sdram_active` is 1 when a release would start, `pall_req` is raised first and the acknowledge stays high. When `pall_done` is seen, `pall_req` drops. Release then follows once the bank flag is 0.
- R9: `refresh_req` follows `refresh_pend` only while the bus is granted away or being reclaimed. It is 0 whenever `bus_owned` is 1.
- R10: Reclaim timing is counted from the edge that samples the negated request. `ctrl_oe` and `ctrl_drive_high` go to 1 three edges later. `back_n` goes to 1 four edges later. `addr_data_oe` and `bus_owned` go to 1 and `ctrl_drive_high` goes to 0 five edges later.
- R11: If the request is withdrawn before release begins, including during a pending precharge-all, `back_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| breq_n | input | 1 | Active-low external bus request |
| cyc_done | input | 1 | Current bus cycle has completed |
| atomic_busy | input | N_ATOMIC | Indivisible sequence in progress flags (line fill, copyback, test-and-set gap, split access, 16-byte DMA) |
| lock | input | 1 | Software lock that holds the bus |
| dma_burst | input | 1 | DMA burst transfer under way |
| dma_prio | input | 2 | Burst priority setting; 00 holds off requests during a burst |
| sdram_active | input | 1 | At least one SDRAM bank is open |
| pall_done | input | 1 | Precharge-all command has completed |
| refresh_pend | input | 1 | SDRAM refresh is due |
| back_n | output | 1 | Active-low bus acknowledge |
| pall_req | output | 1 | Request for a precharge-all command |
| addr_data_oe | output | 1 | Output enable of address and data group |
| ctrl_oe | output | 1 | Output enable of bus control group |
| ctrl_drive_high | output | 1 | Control group forced to the inactive high level |
| bus_owned | output | 1 | Controller owns the bus and may run cycles |
| refresh_req | output | 1 | Asks the outside master to return the bus |
| bus_ph | output | 1 | Half-period phase: 0 after rising, 1 after falling bus edge |

## Verification
Two functions can land in the same cycle: the start of a reclaim and a newly raised refresh demand. The bench negates the request and raises `refresh_pend` at the same sampling edge. It expects `refresh_req` to rise during the reclaim stages and to drop in exactly the cycle where `bus_owned` returns. A second collision occurs when a request is withdrawn while a precharge-all is still pending. There, the completion of the precharge must leave the acknowledge untouched. The release gating is swept over every combination of the indivisible-sequence flags, the lock bit, the burst flag and the priority field. The expected outcome for each combination is computed from R4 to R6.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [3:0] {
        ST_OWN,
        ST_PALL,
        ST_REL_ACK,
        ST_REL_CTRL,
        ST_GRANTED,
        ST_RC_WAIT,
        ST_RC_DRIVE,
        ST_RC_ACK,
        ST_RC_RESUME
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       back_n;
        logic       ad_oe;
        logic       ctl_oe;
        logic       ctl_hi;
        logic       owned;
        logic       pall_req;
        logic       rfsh_req;
    } arb_regs_t;

    localparam arb_regs_t ARB_RESET = '{
        state:    ST_OWN,
        back_n:   1'b1,
        ad_oe:    1'b1,
        ctl_oe:   1'b1,
        ctl_hi:   1'b0,
        owned:    1'b1,
        pall_req: 1'b0,
        rfsh_req: 1'b0
    };

    typedef struct packed {
        logic ph;
        logic req;
    } phase_regs_t;

endpackage

// File: rtl/arb_phase.sv
module arb_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic breq_n,
    output logic ph,
    output logic req_seen
);
    import arb_pkg::*;

    phase_regs_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.ph = ~p_q.ph;
        // the edge leaving a rising-half cycle is the bus falling edge
        if (!p_q.ph) begin
            p_d.req = ~breq_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{ph: 1'b0, req: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign ph       = p_q.ph;
    assign req_seen = p_q.req;
endmodule

// File: rtl/arb_gate.sv
module arb_gate #(
    parameter int N_ATOMIC = 5,
    parameter int PRIO_W   = 2
) (
    input  logic [N_ATOMIC-1:0] atomic_busy,
    input  logic                lock,
    input  logic                dma_burst,
    input  logic [PRIO_W-1:0]   dma_prio,
    output logic                release_ok
);
    localparam logic [PRIO_W-1:0] PRIO_HOLD = '0;

    logic burst_hold;

    always_comb begin
        burst_hold = dma_burst && (dma_prio == PRIO_HOLD);
        release_ok = !(|atomic_busy) && !lock && !burst_hold;
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic req_seen,
    input  logic cyc_done,
    input  logic release_ok,
    input  logic sdram_active,
    input  logic pall_done,
    input  logic refresh_pend,
    output logic back_n,
    output logic pall_req,
    output logic addr_data_oe,
    output logic ctrl_oe,
    output logic ctrl_drive_high,
    output logic bus_owned,
    output logic refresh_req
);
    import arb_pkg::*;

    arb_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_OWN: begin
                if (ph && req_seen && cyc_done && release_ok) begin
                    if (sdram_active) begin
                        r_d.pall_req = 1'b1;
                        r_d.state    = ST_PALL;
                    end else begin
                        r_d.ad_oe = 1'b0;
                        r_d.owned = 1'b0;
                        r_d.state = ST_REL_ACK;
                    end
                end
            end
            ST_PALL: begin
                if (pall_done) begin
                    r_d.pall_req = 1'b0;
                    r_d.state    = ST_OWN;
                end
            end
            ST_REL_ACK: begin
                r_d.back_n = 1'b0;
                r_d.state  = ST_REL_CTRL;
            end
            ST_REL_CTRL: begin
                r_d.ctl_oe = 1'b0;
                r_d.state  = ST_GRANTED;
            end
            ST_GRANTED: begin
                r_d.rfsh_req = refresh_pend;
                if (ph && !req_seen) begin
                    r_d.state = ST_RC_WAIT;
                end
            end
            ST_RC_WAIT: begin
                r_d.rfsh_req = refresh_pend;
                r_d.state    = ST_RC_DRIVE;
            end
            ST_RC_DRIVE: begin
                r_d.rfsh_req = refresh_pend;
                r_d.ctl_oe   = 1'b1;
                r_d.ctl_hi   = 1'b1;
                r_d.state    = ST_RC_ACK;
            end
            ST_RC_ACK: begin
                r_d.rfsh_req = refresh_pend;
                r_d.back_n   = 1'b1;
                r_d.state    = ST_RC_RESUME;
            end
            ST_RC_RESUME: begin
                r_d.rfsh_req = 1'b0;
                r_d.ad_oe    = 1'b1;
                r_d.owned    = 1'b1;
                r_d.ctl_hi   = 1'b0;
                r_d.state    = ST_OWN;
            end
            default: r_d = ARB_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= ARB_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign back_n          = r_q.back_n;
    assign pall_req        = r_q.pall_req;
    assign addr_data_oe    = r_q.ad_oe;
    assign ctrl_oe         = r_q.ctl_oe;
    assign ctrl_drive_high = r_q.ctl_hi;
    assign bus_owned       = r_q.owned;
    assign refresh_req     = r_q.rfsh_req;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N_ATOMIC = 5,
    parameter int PRIO_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                breq_n,
    input  logic                cyc_done,
    input  logic [N_ATOMIC-1:0] atomic_busy,
    input  logic                lock,
    input  logic                dma_burst,
    input  logic [PRIO_W-1:0]   dma_prio,
    input  logic                sdram_active,
    input  logic                pall_done,
    input  logic                refresh_pend,
    output logic                back_n,
    output logic                pall_req,
    output logic                addr_data_oe,
    output logic                ctrl_oe,
    output logic                ctrl_drive_high,
    output logic                bus_owned,
    output logic                refresh_req,
    output logic                bus_ph
);
    logic ph;
    logic req_seen;
    logic release_ok;

    arb_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .breq_n   (breq_n),
        .ph       (ph),
        .req_seen (req_seen)
    );

    arb_gate #(
        .N_ATOMIC (N_ATOMIC),
        .PRIO_W   (PRIO_W)
    ) u_gate (
        .atomic_busy (atomic_busy),
        .lock        (lock),
        .dma_burst   (dma_burst),
        .dma_prio    (dma_prio),
        .release_ok  (release_ok)
    );

    arb_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ph              (ph),
        .req_seen        (req_seen),
        .cyc_done        (cyc_done),
        .release_ok      (release_ok),
        .sdram_active    (sdram_active),
        .pall_done       (pall_done),
        .refresh_pend    (refresh_pend),
        .back_n          (back_n),
        .pall_req        (pall_req),
        .addr_data_oe    (addr_data_oe),
        .ctrl_oe         (ctrl_oe),
        .ctrl_drive_high (ctrl_drive_high),
        .bus_owned       (bus_owned),
        .refresh_req     (refresh_req)
    );

    assign bus_ph = ph;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_ATOMIC = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cyc_done,
    input logic [N_ATOMIC-1:0] atomic_busy,
    input logic                lock,
    input logic                sdram_active,
    input logic                back_n,
    input logic                pall_req,
    input logic                addr_data_oe,
    input logic                ctrl_oe,
    input logic                ctrl_drive_high,
    input logic                bus_owned,
    input logic                refresh_req,
    input logic                bus_ph
);
    AST_OWNED_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_owned |-> (addr_data_oe && ctrl_oe && back_n)); // R1

    AST_FLOAT_ON_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_data_oe) |-> !bus_ph); // R3

    AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(back_n) |-> ($past(!addr_data_oe) && $past(ctrl_oe) && bus_ph)); // R3

    AST_CTRL_FLOAT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_oe) |-> (!$past(back_n) && $past(back_n, 2))); // R3

    AST_NO_FLOAT_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_data_oe) |-> $past(atomic_busy == '0)); // R4

    AST_NO_FLOAT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_data_oe) |-> !$past(lock)); // R5

    AST_NO_FLOAT_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_data_oe) |-> $past(cyc_done)); // R7

    AST_NO_FLOAT_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_data_oe) |-> !$past(sdram_active)); // R8

    AST_NO_ACK_IN_PALL: assert property (@(posedge clk) disable iff (!rst_n)
        pall_req |-> back_n); // R8

    AST_REFRESH_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> !bus_owned); // R9

    AST_HIGH_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_drive_high |-> ctrl_oe); // R10

    AST_RESUME_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_data_oe) |-> ($past(back_n) && !$past(back_n, 2))); // R10
endmodule

bind bus_arbiter arb_checker #(.N_ATOMIC(N_ATOMIC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cyc_done        (cyc_done),
    .atomic_busy     (atomic_busy),
    .lock            (lock),
    .sdram_active    (sdram_active),
    .back_n          (back_n),
    .pall_req        (pall_req),
    .addr_data_oe    (addr_data_oe),
    .ctrl_oe         (ctrl_oe),
    .ctrl_drive_high (ctrl_drive_high),
    .bus_owned       (bus_owned),
    .refresh_req     (refresh_req),
    .bus_ph          (bus_ph)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    localparam int NA = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          breq_n = 1'b1;
    logic          cyc_done = 1'b1;
    logic [NA-1:0] atomic_busy = '0;
    logic          lock = 1'b0;
    logic          dma_burst = 1'b0;
    logic [1:0]    dma_prio = 2'b00;
    logic          sdram_active = 1'b0;
    logic          pall_done = 1'b0;
    logic          refresh_pend = 1'b0;
    logic          back_n, pall_req, addr_data_oe, ctrl_oe;
    logic          ctrl_drive_high, bus_owned, refresh_req, bus_ph;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bus_arbiter #(.N_ATOMIC(NA), .PRIO_W(2)) u_dut (
        .clk (clk), .rst_n (rst_n), .breq_n (breq_n), .cyc_done (cyc_done),
        .atomic_busy (atomic_busy), .lock (lock), .dma_burst (dma_burst),
        .dma_prio (dma_prio), .sdram_active (sdram_active),
        .pall_done (pall_done), .refresh_pend (refresh_pend),
        .back_n (back_n), .pall_req (pall_req), .addr_data_oe (addr_data_oe),
        .ctrl_oe (ctrl_oe), .ctrl_drive_high (ctrl_drive_high),
        .bus_owned (bus_owned), .refresh_req (refresh_req), .bus_ph (bus_ph)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench at a falling clk edge inside a bus_ph=0 cycle
    task automatic align_rise();
        @(negedge clk);
        while (bus_ph != 1'b0) @(negedge clk);
    endtask

    task automatic wait_ack(input int lim);
        for (int i = 0; i < lim && back_n; i++) @(negedge clk);
    endtask

    task automatic wait_owned(input int lim);
        for (int i = 0; i < lim && !bus_owned; i++) @(negedge clk);
    endtask

    task automatic give_back();
        align_rise();
        breq_n = 1'b1;
        wait_owned(20);
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset values
        check("R1 bus_owned", int'(bus_owned), 1);
        check("R1 back_n", int'(back_n), 1);
        check("R1 addr_data_oe", int'(addr_data_oe), 1);
        check("R1 ctrl_oe", int'(ctrl_oe), 1);
        check("R1 ctrl_drive_high", int'(ctrl_drive_high), 0);
        check("R1 pall_req", int'(pall_req), 0);
        check("R1 refresh_req", int'(refresh_req), 0);

        // R2 low pulse only inside a bus_ph=1 cycle is not sampled
        align_rise();
        step(1);
        breq_n = 1'b0;
        step(1);
        breq_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            check("R2 ignored pulse back_n", int'(back_n), 1);
            check("R2 ignored pulse addr_data_oe", int'(addr_data_oe), 1);
            step(1);
        end

        // R3 release staging timing, R9 refresh_req low before grant
        refresh_pend = 1'b1;
        align_rise();
        breq_n = 1'b0;
        step(1);
        check("R3 edge1 addr_data_oe", int'(addr_data_oe), 1);
        check("R9 refresh not while owned", int'(refresh_req), 0);
        step(1);
        check("R3 edge2 addr_data_oe", int'(addr_data_oe), 0);
        check("R3 edge2 bus_owned", int'(bus_owned), 0);
        check("R3 edge2 phase", int'(bus_ph), 0);
        check("R3 edge2 back_n", int'(back_n), 1);
        step(1);
        check("R3 edge3 back_n", int'(back_n), 0);
        check("R3 edge3 phase", int'(bus_ph), 1);
        check("R3 edge3 ctrl_oe", int'(ctrl_oe), 1);
        step(1);
        check("R3 edge4 ctrl_oe", int'(ctrl_oe), 0);
        step(1);
        check("R9 refresh while granted", int'(refresh_req), 1);
        refresh_pend = 1'b0;
        step(1);
        check("R9 refresh follows pend", int'(refresh_req), 0);

        // R10 reclaim timing with R9 refresh raised in the same cycle
        align_rise();
        breq_n = 1'b1;
        refresh_pend = 1'b1;
        step(2);
        check("R9 refresh during reclaim", int'(refresh_req), 1);
        step(2);
        check("R10 ctrl_oe back", int'(ctrl_oe), 1);
        check("R10 drive high", int'(ctrl_drive_high), 1);
        check("R10 back_n still low", int'(back_n), 0);
        step(1);
        check("R10 back_n negated", int'(back_n), 1);
        check("R10 addr_data still off", int'(addr_data_oe), 0);
        step(1);
        check("R10 addr_data_oe resumed", int'(addr_data_oe), 1);
        check("R10 bus_owned", int'(bus_owned), 1);
        check("R10 drive high released", int'(ctrl_drive_high), 0);
        check("R9 refresh cleared at regain", int'(refresh_req), 0);
        refresh_pend = 1'b0;
        step(2);

        // R7 bus cycle not done
        cyc_done = 1'b0;
        align_rise();
        breq_n = 1'b0;
        step(10);
        check("R7 held by open cycle", int'(back_n), 1);
        cyc_done = 1'b1;
        wait_ack(10);
        check("R7 release after cycle end", int'(back_n), 0);
        give_back();

        // R4 R5 R6 sweep of all gating combinations
        for (int m = 0; m < (1 << NA); m++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int db = 0; db < 2; db++) begin
                    for (int pr = 0; pr < 4; pr++) begin
                        bit allow;
                        allow = (m == 0) && (lk == 0) && !(db == 1 && pr == 0);
                        align_rise();
                        atomic_busy = NA'(m);
                        lock        = lk[0];
                        dma_burst   = db[0];
                        dma_prio    = pr[1:0];
                        breq_n      = 1'b0;
                        step(8);
                        if (m != 0)
                            check("R4 atomic gate", int'(back_n), allow ? 0 : 1);
                        else if (lk != 0)
                            check("R5 lock gate", int'(back_n), allow ? 0 : 1);
                        else
                            check("R6 burst priority gate", int'(back_n), allow ? 0 : 1);
                        atomic_busy = '0;
                        lock        = 1'b0;
                        dma_burst   = 1'b0;
                        wait_ack(10);
                        give_back();
                    end
                end
            end
        end
        dma_prio = 2'b00;

        // R8 precharge-all before release
        sdram_active = 1'b1;
        align_rise();
        breq_n = 1'b0;
        step(2);
        check("R8 pall_req raised", int'(pall_req), 1);
        step(6);
        check("R8 pall_req held", int'(pall_req), 1);
        check("R8 no ack during pall", int'(back_n), 1);
        pall_done    = 1'b1;
        sdram_active = 1'b0;
        step(1);
        pall_done = 1'b0;
        check("R8 pall_req dropped", int'(pall_req), 0);
        wait_ack(10);
        check("R8 release after pall", int'(back_n), 0);
        give_back();

        // R11 request withdrawn while precharge pending
        sdram_active = 1'b1;
        align_rise();
        breq_n = 1'b0;
        step(3);
        check("R11 pall pending", int'(pall_req), 1);
        breq_n = 1'b1;
        step(3);
        pall_done    = 1'b1;
        sdram_active = 1'b0;
        step(1);
        pall_done = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check("R11 no ack after withdraw", int'(back_n), 1);
            step(1);
        end
        check("R11 still owned", int'(bus_owned), 1);
        check("R11 pall cleared", int'(pall_req), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule